// File: doc/BRIEF.md
# Burst register bridge for a serial-bus controller

This block is a slave socket with an 8-bit data word. It places a register file between a host interconnect and a serial-bus message controller. The host issues one request per burst. The request carries a command, a start address and the burst qualifiers. Write data then follows on its own handshaked data phase, and read data comes back as one response beat per cycle. Every beat moves the address up by 4.

The register file holds several groups of registers. The host writes four setup bytes, four filter bytes and a 102-bit transmit message, and the controller sees all of these directly on output ports. The controller supplies a 102-bit receive message, which is captured when the controller signals a completed frame. It also supplies status bits and two error counters, which the host can only read. No interrupt exists: the host polls a sticky new-frame flag in the first status register, and reading that register clears the flag.

Top module: `burst_reg_bridge`

Register map. Each entry is a word index; the byte address is 4 × index.
- 0–3: setup, read/write.
- 4: status A.
- 5: status B.
- 6–9: filter, read/write.
- 10–22: transmit message bytes 0–12, read/write.
- 23–35: receive message bytes 0–12.
- 36: transmit error count.
- 37: receive error count.

## Requirements
- R1: After reset the outputs are as follows. cmd_ready_o is 1, wready_o is 0, resp_o is NULL (2'b00) and resp_last_o is 0. Every host-writable register reads 0, and setup_o, filter_o and tx_msg_o are all zero.
- R2: cmd_i uses these codes: 0 idle, 1 write, 2 read, 3 reserved. A non-idle command is taken at a clock edge where cmd_ready_o is 1. cmd_ready_o is 1 only while no burst is in progress. The reserved code gives a single ERR beat with resp_last_o set.
- R3: A read returns burst_len_i beats, one per cycle, starting the cycle after the request is taken. Each beat reads the address of the previous beat plus 4. A good beat carries DVA (2'b01) with its data on rdata_o. resp_last_o is 1 only on the final beat.
- R4: A write beat is taken in each cycle where wvalid_i and wready_o are both 1. The burst ends with the beat that has wlast_i set, whatever burst_len_i says. A single response with resp_last_o set follows in the next cycle.
- R5: An address that is not a multiple of 4, or whose word index is above 37, is in error. Such an address gives ERR (2'b11) on a read beat. In a write burst it makes the single response ERR. Beats at good addresses in the same burst still take effect.
- R6: A write beat aimed at status, receive-message or counter registers leaves that register unchanged and makes the write response ERR.
- R7: A request is rejected in any of these cases: burst_kind_i is not 0 (incrementing), burst_len_i is 0, or the length is above 1 while burst_precise_i or burst_single_i is 0. A rejected request still runs its beats but answers ERR on all of them and writes nothing. A length of 0 gives one read beat.
- R8: Transmit byte k (index 10+k) holds tx_msg_o bits 8k+7..8k. Byte 12 holds only bits 101..96; its upper two bits are dropped on write and read back as 0.
- R9: On a rising edge of rx_done_i, rx_msg_i is captured. Receive byte k (index 23+k) returns bits 8k+7..8k of the capture, with bits beyond 101 reading as 0. At all other times the captured message does not change.
- R10: Status A holds the following bits:
  - bit 0: a sticky new-frame flag, set by a capture.
  - bit 1: bus_off_i.
  - bit 2: err_passive_i.
  - bit 3: tx_busy_i.
  - bits 7..4: zero.

  A good read beat of status A clears bit 0. If a capture happens in the same cycle, the flag stays set.
- R11: Status B returns ctrl_status_i. Index 36 returns tx_err_cnt_i and index 37 returns rx_err_cnt_i, all live.
- R12: Setup byte i reads back as written and drives setup_o[8i+7:8i]. Filter byte i does the same on filter_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Request command |
| addr_i | input | ADDR_W | Request start byte address |
| burst_len_i | input | LEN_W | Burst beat count |
| burst_kind_i | input | 3 | Address sequence, 0 = incrementing |
| burst_precise_i | input | 1 | Length is exact |
| burst_single_i | input | 1 | One request for the whole burst |
| cmd_ready_o | output | 1 | Request taken |
| wvalid_i | input | 1 | Write beat valid |
| wdata_i | input | 8 | Write beat data |
| wlast_i | input | 1 | Final write beat |
| wready_o | output | 1 | Write beat taken |
| resp_o | output | 2 | Response code |
| rdata_o | output | 8 | Read beat data |
| resp_last_o | output | 1 | Final response beat |
| setup_o | output | 32 | Setup bytes to the controller |
| filter_o | output | 32 | Filter bytes to the controller |
| tx_msg_o | output | 102 | Transmit message to the controller |
| rx_msg_i | input | 102 | Receive message from the controller |
| rx_done_i | input | 1 | Frame received, capture on rising edge |
| bus_off_i | input | 1 | Controller bus-off status |
| err_passive_i | input | 1 | Controller error-passive status |
| tx_busy_i | input | 1 | Controller transmit busy |
| ctrl_status_i | input | 8 | Further controller status byte |
| tx_err_cnt_i | input | 8 | Transmit error count |
| rx_err_cnt_i | input | 8 | Receive error count |

## Verification
The hardest situation to reach is the collision between a status A read beat and a new frame arriving in the same cycle. The clear must lose to the set. Only one cycle of alignment between the read response and the rx_done_i edge produces it. The bench creates it on purpose: it raises rx_done_i at the very cycle it samples the first read beat, then polls status A and the receive bytes again. Random bursts from a fixed seed also cover several other cases:
- bursts that cross from writable into read-only registers or past the end of the map;
- unaligned starts;
- gaps in the write data stream;
- qualifiers that must be rejected.

// File: rtl/brb_pkg.sv
package brb_pkg;
  localparam int MSG_W     = 102;
  localparam int MSG_BYTES = (MSG_W + 7) / 8;
  localparam int N_SETUP   = 4;
  localparam int N_FILT    = 4;

  localparam int IDX_SETUP = 0;
  localparam int IDX_STAT0 = IDX_SETUP + N_SETUP;
  localparam int IDX_STAT1 = IDX_STAT0 + 1;
  localparam int IDX_FILT  = IDX_STAT1 + 1;
  localparam int IDX_TX    = IDX_FILT + N_FILT;
  localparam int IDX_RX    = IDX_TX + MSG_BYTES;
  localparam int IDX_TXERR = IDX_RX + MSG_BYTES;
  localparam int IDX_RXERR = IDX_TXERR + 1;
  localparam int N_REGS    = IDX_RXERR + 1;

  typedef enum logic [1:0] {CMD_IDLE = 2'd0, CMD_WR = 2'd1, CMD_RD = 2'd2, CMD_RSV = 2'd3} cmd_e;
  typedef enum logic [1:0] {RSP_NULL = 2'd0, RSP_DVA = 2'd1, RSP_FAIL = 2'd2, RSP_ERR = 2'd3} rsp_e;
  typedef enum logic [3:0] {
    R_NONE, R_SETUP, R_STAT0, R_STAT1, R_FILT, R_TX, R_RX, R_TXERR, R_RXERR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [4:0] sub;
    logic       ok;
    logic       writable;
  } dec_t;
endpackage

// File: rtl/brb_decode.sv
module brb_decode
  import brb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  int widx;

  always_comb begin
    widx  = int'(addr_i[ADDR_W-1:2]);
    dec_o = '{kind: R_NONE, sub: 5'd0, ok: 1'b0, writable: 1'b0};
    if (addr_i[1:0] == 2'b00 && widx < N_REGS) begin
      dec_o.ok = 1'b1;
      if (widx < IDX_STAT0) begin
        dec_o.kind = R_SETUP; dec_o.sub = 5'(widx - IDX_SETUP); dec_o.writable = 1'b1;
      end else if (widx == IDX_STAT0) begin
        dec_o.kind = R_STAT0;
      end else if (widx == IDX_STAT1) begin
        dec_o.kind = R_STAT1;
      end else if (widx < IDX_TX) begin
        dec_o.kind = R_FILT; dec_o.sub = 5'(widx - IDX_FILT); dec_o.writable = 1'b1;
      end else if (widx < IDX_RX) begin
        dec_o.kind = R_TX; dec_o.sub = 5'(widx - IDX_TX); dec_o.writable = 1'b1;
      end else if (widx < IDX_TXERR) begin
        dec_o.kind = R_RX; dec_o.sub = 5'(widx - IDX_RX);
      end else if (widx == IDX_TXERR) begin
        dec_o.kind = R_TXERR;
      end else begin
        dec_o.kind = R_RXERR;
      end
    end
  end
endmodule

// File: rtl/brb_ctrl.sv
module brb_ctrl
  import brb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [2:0]        kind_i,
  input  logic              precise_i,
  input  logic              single_i,
  input  logic              wvalid_i,
  input  logic              wlast_i,
  input  logic              dec_ok_i,
  input  logic              dec_wr_i,
  output logic              cmd_ready_o,
  output logic              wready_o,
  output logic [1:0]        resp_o,
  output logic              resp_last_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              we_o,
  output logic              rd_o
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_WRSP, S_RD} st_e;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [LEN_W-1:0]  ONE  = LEN_W'(1);

  st_e               st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              bad_q, err_q;
  logic              param_bad, rd_bad, wr_bad;

  assign param_bad = (cmd_i == CMD_RSV) || (kind_i != 3'd0) || (len_i == '0) ||
                     ((len_i != ONE) && !(precise_i && single_i));
  assign rd_bad    = bad_q || !dec_ok_i;
  assign wr_bad    = bad_q || !dec_ok_i || !dec_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      left_q <= '0;
      bad_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (cmd_i != CMD_IDLE) begin
          addr_q <= addr_i;
          left_q <= (len_i == '0 || cmd_i == CMD_RSV) ? ONE : len_i;
          bad_q  <= param_bad;
          err_q  <= 1'b0;
          st_q   <= (cmd_i == CMD_WR) ? S_WR : S_RD;
        end
        S_WR: if (wvalid_i) begin
          addr_q <= addr_q + STEP;
          err_q  <= err_q | wr_bad;
          if (wlast_i) st_q <= S_WRSP;
        end
        S_WRSP: st_q <= S_IDLE;
        S_RD: begin
          addr_q <= addr_q + STEP;
          left_q <= left_q - ONE;
          if (left_q == ONE) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready_o = (st_q == S_IDLE);
    wready_o    = (st_q == S_WR);
    we_o        = (st_q == S_WR) && wvalid_i && !wr_bad;
    rd_o        = (st_q == S_RD) && !rd_bad;
    resp_o      = RSP_NULL;
    resp_last_o = 1'b0;
    if (st_q == S_WRSP) begin
      resp_o      = err_q ? RSP_ERR : RSP_DVA;
      resp_last_o = 1'b1;
    end else if (st_q == S_RD) begin
      resp_o      = rd_bad ? RSP_ERR : RSP_DVA;
      resp_last_o = (left_q == ONE);
    end
  end

  assign cur_addr_o = addr_q;

  // R2: taking a request closes the request channel
  a_r2_busy_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && cmd_i != CMD_IDLE) |=> !cmd_ready_o);
  // R3: after the final beat the socket is free again
  a_r3_last_then_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_last_o |=> cmd_ready_o);
  // R4: the data phase closes straight into its response
  a_r4_wr_ends_in_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wready_o) |-> (resp_last_o && resp_o != RSP_NULL));
  // R2: request, data and response phases never overlap
  a_r2_phase_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_ready_o, wready_o, resp_o != RSP_NULL}));
endmodule

// File: rtl/brb_regfile.sv
module brb_regfile
  import brb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 rd_i,
  input  dec_t                 dec_i,
  input  logic [7:0]           wdata_i,
  input  logic [MSG_W-1:0]     rx_msg_i,
  input  logic                 rx_done_i,
  input  logic                 bus_off_i,
  input  logic                 err_passive_i,
  input  logic                 tx_busy_i,
  input  logic [7:0]           ctrl_status_i,
  input  logic [7:0]           tx_err_cnt_i,
  input  logic [7:0]           rx_err_cnt_i,
  output logic [7:0]           rdata_o,
  output logic [8*N_SETUP-1:0] setup_o,
  output logic [8*N_FILT-1:0]  filter_o,
  output logic [MSG_W-1:0]     tx_msg_o
);
  localparam int SW       = $clog2(N_SETUP);
  localparam int FW       = $clog2(N_FILT);
  localparam int MW       = $clog2(MSG_BYTES);
  localparam int TOP_BITS = MSG_W - 8 * (MSG_BYTES - 1);
  localparam logic [7:0] TOP_MASK = 8'((1 << TOP_BITS) - 1);

  logic [7:0]       setup_q [N_SETUP];
  logic [7:0]       filt_q  [N_FILT];
  logic [7:0]       tx_q    [MSG_BYTES];
  logic [MSG_W-1:0] rx_q;
  logic             rx_new_q, rx_prev_q, rx_rise;

  assign rx_rise = rx_done_i && !rx_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SETUP; i++) setup_q[i] <= '0;
      for (int i = 0; i < N_FILT; i++) filt_q[i] <= '0;
      for (int i = 0; i < MSG_BYTES; i++) tx_q[i] <= '0;
    end else if (we_i) begin
      unique case (dec_i.kind)
        R_SETUP: setup_q[dec_i.sub[SW-1:0]] <= wdata_i;
        R_FILT:  filt_q[dec_i.sub[FW-1:0]]  <= wdata_i;
        R_TX:    tx_q[dec_i.sub[MW-1:0]] <= (int'(dec_i.sub) == MSG_BYTES - 1) ?
                                            (wdata_i & TOP_MASK) : wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      rx_new_q  <= 1'b0;
      rx_prev_q <= 1'b0;
    end else begin
      rx_prev_q <= rx_done_i;
      if (rx_rise) rx_q <= rx_msg_i;
      // capture wins over a same-cycle clearing read
      if (rx_rise) rx_new_q <= 1'b1;
      else if (rd_i && dec_i.kind == R_STAT0) rx_new_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (dec_i.kind)
      R_SETUP: rdata_o = setup_q[dec_i.sub[SW-1:0]];
      R_STAT0: rdata_o = {4'b0, tx_busy_i, err_passive_i, bus_off_i, rx_new_q};
      R_STAT1: rdata_o = ctrl_status_i;
      R_FILT:  rdata_o = filt_q[dec_i.sub[FW-1:0]];
      R_TX:    rdata_o = tx_q[dec_i.sub[MW-1:0]];
      R_RX: for (int j = 0; j < 8; j++) begin
        if (8 * int'(dec_i.sub) + j < MSG_W) rdata_o[j] = rx_q[8 * int'(dec_i.sub) + j];
      end
      R_TXERR: rdata_o = tx_err_cnt_i;
      R_RXERR: rdata_o = rx_err_cnt_i;
      default: rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < N_SETUP; g++) begin : g_setup
    assign setup_o[8*g +: 8] = setup_q[g];
  end
  for (genvar g = 0; g < N_FILT; g++) begin : g_filt
    assign filter_o[8*g +: 8] = filt_q[g];
  end

  always_comb begin
    for (int b = 0; b < MSG_W; b++) tx_msg_o[b] = tx_q[b / 8][b % 8];
  end

  // R9: captured message only moves on a capture edge
  a_r9_rx_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_rise |=> $stable(rx_q));
  // R10: a capture always leaves the new-frame flag set
  a_r10_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rise |=> rx_new_q);
  // R6 R12: host-writable state only changes on an accepted write
  a_r12_setup_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(setup_o) && $stable(filter_o) && $stable(tx_msg_o)));
endmodule

// File: rtl/burst_reg_bridge.sv
module burst_reg_bridge
  import brb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  burst_len_i,
  input  logic [2:0]        burst_kind_i,
  input  logic              burst_precise_i,
  input  logic              burst_single_i,
  output logic              cmd_ready_o,
  input  logic              wvalid_i,
  input  logic [7:0]        wdata_i,
  input  logic              wlast_i,
  output logic              wready_o,
  output logic [1:0]        resp_o,
  output logic [7:0]        rdata_o,
  output logic              resp_last_o,
  output logic [31:0]       setup_o,
  output logic [31:0]       filter_o,
  output logic [101:0]      tx_msg_o,
  input  logic [101:0]      rx_msg_i,
  input  logic              rx_done_i,
  input  logic              bus_off_i,
  input  logic              err_passive_i,
  input  logic              tx_busy_i,
  input  logic [7:0]        ctrl_status_i,
  input  logic [7:0]        tx_err_cnt_i,
  input  logic [7:0]        rx_err_cnt_i
);
  logic [ADDR_W-1:0] cur_addr;
  dec_t              dec;
  logic              we, rd;

  brb_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .cmd_i, .addr_i,
    .len_i(burst_len_i), .kind_i(burst_kind_i),
    .precise_i(burst_precise_i), .single_i(burst_single_i),
    .wvalid_i, .wlast_i,
    .dec_ok_i(dec.ok), .dec_wr_i(dec.writable),
    .cmd_ready_o, .wready_o, .resp_o, .resp_last_o,
    .cur_addr_o(cur_addr), .we_o(we), .rd_o(rd)
  );

  brb_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(cur_addr), .dec_o(dec));

  brb_regfile u_regs (
    .clk_i, .rst_ni, .we_i(we), .rd_i(rd), .dec_i(dec), .wdata_i,
    .rx_msg_i, .rx_done_i, .bus_off_i, .err_passive_i, .tx_busy_i,
    .ctrl_status_i, .tx_err_cnt_i, .rx_err_cnt_i,
    .rdata_o, .setup_o, .filter_o, .tx_msg_o
  );
endmodule

// File: tb/burst_reg_bridge_tb.sv
module burst_reg_bridge_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cmd_i = '0;
  logic [7:0]   addr_i = '0;
  logic [4:0]   len_i = '0;
  logic [2:0]   kind_i = '0;
  logic         prec_i = 1'b1, sgl_i = 1'b1;
  logic         cmd_ready_o, wready_o, resp_last_o;
  logic         wvalid_i = 1'b0, wlast_i = 1'b0;
  logic [7:0]   wdata_i = '0;
  logic [1:0]   resp_o;
  logic [7:0]   rdata_o;
  logic [31:0]  setup_o, filter_o;
  logic [101:0] tx_msg_o;
  logic [101:0] rx_msg_i = '0;
  logic         rx_done_i = 1'b0, bus_off_i = 1'b0, err_passive_i = 1'b0, tx_busy_i = 1'b0;
  logic [7:0]   ctrl_status_i = '0, tx_err_cnt_i = '0, rx_err_cnt_i = '0;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0]   m_setup [4];
  logic [7:0]   m_filt  [4];
  logic [7:0]   m_tx    [13];
  logic [101:0] m_rx;
  bit           m_new;
  logic [7:0]   wbuf    [32];

  always #10 clk = ~clk;

  burst_reg_bridge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i, .addr_i, .burst_len_i(len_i),
    .burst_kind_i(kind_i), .burst_precise_i(prec_i), .burst_single_i(sgl_i),
    .cmd_ready_o, .wvalid_i, .wdata_i, .wlast_i, .wready_o, .resp_o, .rdata_o,
    .resp_last_o, .setup_o, .filter_o, .tx_msg_o, .rx_msg_i, .rx_done_i,
    .bus_off_i, .err_passive_i, .tx_busy_i, .ctrl_status_i, .tx_err_cnt_i, .rx_err_cnt_i
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit mp_ok(int a);
    return (a % 4 == 0) && (a / 4 < 38);
  endfunction
  function automatic bit mp_wr(int i);
    return (i < 4) || (i >= 6 && i < 23);
  endfunction
  function automatic logic [7:0] exp_rd(int i);
    logic [7:0] v = '0;
    if (i < 4) v = m_setup[i];
    else if (i == 4) v = {4'b0, tx_busy_i, err_passive_i, bus_off_i, m_new};
    else if (i == 5) v = ctrl_status_i;
    else if (i < 10) v = m_filt[i-6];
    else if (i < 23) v = m_tx[i-10];
    else if (i < 36) begin
      for (int j = 0; j < 8; j++) if (8*(i-23)+j < 102) v[j] = m_rx[8*(i-23)+j];
    end else if (i == 36) v = tx_err_cnt_i;
    else v = rx_err_cnt_i;
    return v;
  endfunction

  task automatic do_read(input int a, input int len, input logic [2:0] kd, input bit pr, input bit sg,
                         input logic [1:0] c, input bit pulse, input logic [101:0] pmsg);
    bit pbad = (kd != 0) || (len == 0) || (c == 2'd3) || (len != 1 && !(pr && sg));
    int nb = (len == 0 || c == 2'd3) ? 1 : len;
    @(negedge clk);
    cmd_i = c; addr_i = a[7:0]; len_i = len[4:0]; kind_i = kd; prec_i = pr; sgl_i = sg;
    @(negedge clk);
    cmd_i = 2'd0;
    chk(cmd_ready_o == 1'b0, "R2 busy during read", cmd_ready_o, 0);
    for (int k = 0; k < nb; k++) begin
      int ea = (a + 4*k) & 255;
      bit er = pbad || !mp_ok(ea);
      chk(resp_o == (er ? 2'd3 : 2'd1), er ? "R5 R7 read ERR" : "R3 read DVA", resp_o, er ? 3 : 1);
      chk(resp_last_o == (k == nb-1), "R3 resp_last", resp_last_o, k == nb-1);
      if (!er) begin
        chk(rdata_o == exp_rd(ea/4), "R3 R8 R9 R10 R11 R12 read data", rdata_o, exp_rd(ea/4));
        if (ea == 16) m_new = 0;
      end
      if (pulse && k == 0) begin
        rx_msg_i = pmsg; rx_done_i = 1'b1; m_rx = pmsg; m_new = 1;
      end
      @(negedge clk);
      rx_done_i = 1'b0;
    end
    chk(cmd_ready_o == 1'b1 && resp_o == 2'd0, "R2 free after read", {cmd_ready_o, resp_o}, 3'b100);
  endtask

  task automatic do_write(input int a, input int len, input logic [2:0] kd, input bit pr, input bit sg,
                          input int nb, input bit gaps);
    bit pbad = (kd != 0) || (len == 0) || (len != 1 && !(pr && sg));
    bit er = pbad;
    @(negedge clk);
    cmd_i = 2'd1; addr_i = a[7:0]; len_i = len[4:0]; kind_i = kd; prec_i = pr; sgl_i = sg;
    @(negedge clk);
    cmd_i = 2'd0;
    for (int k = 0; k < nb; k++) begin
      int ea = (a + 4*k) & 255;
      bit bk = !mp_ok(ea) || !mp_wr(ea/4);
      if (gaps && ($urandom % 3 == 0)) begin
        wvalid_i = 1'b0;
        @(negedge clk);
        chk(wready_o == 1'b1 && resp_o == 2'd0, "R4 gap holds data phase", {wready_o, resp_o}, 3'b100);
      end
      wvalid_i = 1'b1; wdata_i = wbuf[k]; wlast_i = (k == nb-1);
      er = er | bk;
      if (!pbad && !bk) begin
        int i = ea / 4;
        if (i < 4) m_setup[i] = wbuf[k];
        else if (i < 10) m_filt[i-6] = wbuf[k];
        else m_tx[i-10] = (i == 22) ? (wbuf[k] & 8'h3f) : wbuf[k];
      end
      @(negedge clk);
    end
    wvalid_i = 1'b0; wlast_i = 1'b0;
    chk(resp_o == (er ? 2'd3 : 2'd1) && resp_last_o, er ? "R5 R6 R7 write ERR" : "R4 write DVA",
        {resp_o, resp_last_o}, {er ? 2'd3 : 2'd1, 1'b1});
    @(negedge clk);
    chk(cmd_ready_o == 1'b1 && resp_o == 2'd0, "R4 single response", {cmd_ready_o, resp_o}, 3'b100);
  endtask

  task automatic chk_outputs();
    logic [101:0] t = '0;
    for (int b = 0; b < 102; b++) t[b] = m_tx[b/8][b%8];
    chk(tx_msg_o == t, "R8 tx_msg_o", tx_msg_o, t);
    chk(setup_o == {m_setup[3], m_setup[2], m_setup[1], m_setup[0]}, "R12 setup_o",
        setup_o, {m_setup[3], m_setup[2], m_setup[1], m_setup[0]});
    chk(filter_o == {m_filt[3], m_filt[2], m_filt[1], m_filt[0]}, "R12 filter_o",
        filter_o, {m_filt[3], m_filt[2], m_filt[1], m_filt[0]});
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 4; i++) begin m_setup[i] = '0; m_filt[i] = '0; end
    for (int i = 0; i < 13; i++) m_tx[i] = '0;
    m_rx = '0; m_new = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready_o && !wready_o && resp_o == 2'd0 && !resp_last_o, "R1 reset handshake",
        {cmd_ready_o, wready_o, resp_o, resp_last_o}, 5'b10000);
    chk_outputs();
    do_read(0, 10, 3'd0, 1, 1, 2'd2, 0, '0);

    // R3 R12 directed setup and filter burst
    for (int k = 0; k < 10; k++) wbuf[k] = 8'(8'h11 * (k + 1));
    do_write(0, 10, 3'd0, 1, 1, 10, 0); // crosses read-only status: R6
    chk_outputs();
    do_read(0, 10, 3'd0, 1, 1, 2'd2, 0, '0);

    // R8 full transmit message including masked top byte
    for (int k = 0; k < 13; k++) wbuf[k] = 8'hff - 8'(k);
    do_write(40, 13, 3'd0, 1, 1, 13, 1);
    chk_outputs();
    do_read(40, 13, 3'd0, 1, 1, 2'd2, 0, '0);

    // R9 R10 capture, poll, clear
    bus_off_i = 1'b1; tx_busy_i = 1'b1; ctrl_status_i = 8'h5a; tx_err_cnt_i = 8'd7; rx_err_cnt_i = 8'd200;
    @(negedge clk);
    rx_msg_i = {38'h2a_bcde_f012, 64'h0123_4567_89ab_cdef}; rx_done_i = 1'b1;
    m_rx = rx_msg_i; m_new = 1;
    @(negedge clk); rx_done_i = 1'b0;
    rx_msg_i = '1; // no edge: must not be taken (R9)
    @(negedge clk);
    do_read(92, 15, 3'd0, 1, 1, 2'd2, 0, '0);
    do_read(16, 2, 3'd0, 1, 1, 2'd2, 0, '0);
    do_read(16, 1, 3'd0, 1, 1, 2'd2, 0, '0);

    // R10 clear collides with capture: flag stays set
    do_read(16, 1, 3'd0, 1, 1, 2'd2, 1, {6'h15, 96'h0f0e_0d0c_0b0a_0908_0706_0504});
    do_read(16, 1, 3'd0, 1, 1, 2'd2, 0, '0);
    do_read(92, 13, 3'd0, 1, 1, 2'd2, 0, '0);

    // R5 unaligned and beyond map, R2 reserved code, R7 bad qualifiers
    do_read(2, 3, 3'd0, 1, 1, 2'd2, 0, '0);
    do_read(144, 4, 3'd0, 1, 1, 2'd2, 0, '0);
    do_read(0, 1, 3'd0, 1, 1, 2'd3, 0, '0);
    do_read(0, 4, 3'd2, 1, 1, 2'd2, 0, '0);
    do_read(0, 4, 3'd0, 0, 1, 2'd2, 0, '0);
    do_read(0, 0, 3'd0, 1, 1, 2'd2, 0, '0);
    wbuf[0] = 8'h99; wbuf[1] = 8'h98;
    do_write(0, 2, 3'd0, 1, 0, 2, 0);
    do_write(1, 1, 3'd0, 1, 1, 1, 0);
    do_write(140, 2, 3'd0, 1, 1, 2, 0);
    chk_outputs();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int a = 4 * int'($urandom % 41);
      int ln = 1 + int'($urandom % 8);
      logic [2:0] kd = ($urandom % 12 == 0) ? 3'(1 + $urandom % 7) : 3'd0;
      bit pr = ($urandom % 10 != 0);
      bit sg = ($urandom % 10 != 0);
      if ($urandom % 15 == 0) a = a + 1 + int'($urandom % 3);
      bus_off_i = 1'($urandom); err_passive_i = 1'($urandom); tx_busy_i = 1'($urandom);
      ctrl_status_i = 8'($urandom); tx_err_cnt_i = 8'($urandom); rx_err_cnt_i = 8'($urandom);
      if ($urandom % 8 == 0) begin
        @(negedge clk);
        rx_msg_i = {$urandom, $urandom, $urandom, $urandom}; rx_done_i = 1'b1;
        m_rx = rx_msg_i; m_new = 1;
        @(negedge clk); rx_done_i = 1'b0;
      end
      if ($urandom % 2 == 0) begin
        for (int k = 0; k < ln; k++) wbuf[k] = 8'($urandom);
        do_write(a, ln, kd, pr, sg, ln, 1);
      end else begin
        do_read(a, ln, kd, pr, sg, 2'd2, 0, '0);
      end
    end
    chk_outputs();
    do_read(0, 20, 3'd0, 1, 1, 2'd2, 0, '0);
    do_read(80, 20, 3'd0, 1, 1, 2'd2, 0, '0);

    summary();
    $finish;
  end
endmodule